// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block turns the input pins of three 8-bit general-purpose ports (named A, B and F) into interrupt requests. Each pin is brought through a two-flop synchroniser. Each line is then sensed in one of four ways: active-high level, active-low level, rising edge or falling edge. Level conditions pass straight through to the status bit while they last. An edge sets a sticky flag, and that flag stays set until software acknowledges it by writing a 1 to the matching bit of the port's acknowledge register.

A per-line enable gates both the status and the interrupt outputs. Ports A and B share one combined interrupt request. Each of the eight lines of port F has an interrupt output of its own. Software drives the block through a simple register write strobe and reads it through a combinational read port. Register fields are one byte wide inside a 32-bit data word.

Top module: `gpio_sense_ctrl`

## Requirements
- R1: With sense bit 0 (level), a line's status equals its synchronised pin when its polarity bit is 1 and the inverted pin when its polarity bit is 0. It follows a pin change two clock edges after the change.
- R2: With sense bit 1 (edge), a rising edge (polarity 1) or a falling edge (polarity 0) of the synchronised pin sets a sticky flag three clock edges after the pin changes. The opposite edge sets nothing, and the flag stays set after the pin returns.
- R3: A line whose enable bit is 0 shows status 0 and requests no interrupt. Its edge flag is cleared while it is disabled, so an edge seen during that time, or a flag held when it was disabled, is not reported after it is enabled again.
- R4: Writing the acknowledge register clears the edge flag of every bit written as 1, and bits written as 0 keep their flag. The status reads 0 in the cycle after the write.
- R5: If a qualifying edge arrives in the same cycle as an acknowledge write to its bit, the flag stays set.
- R6: irq_ab is 1 exactly when any status bit of port A or port B is 1. Port F status never drives it.
- R7: irq_f[i] equals status bit i of port F.
- R8: The register map, with bits [7:0] holding one bit per line (bit i = line i): port A sense 0x90, polarity 0x94, acknowledge 0x98, enable 0x9C, status 0xA0. Port B uses 0xAC, 0xB0, 0xB4, 0xB8, 0xBC. Port F uses 0x4C, 0x50, 0x54, 0x58, 0x5C. Sense, polarity and enable read back as written. Acknowledge and unmapped addresses read 0. Write data bits [31:8] are ignored and read as 0.
- R9: After reset every configuration register is 0, every status reads 0, and all interrupt outputs are low.
- R10: Level lines keep no memory: the status clears as soon as the pin condition ends, and an acknowledge write does not change a level line's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 8 | Port A input pins (asynchronous) |
| pin_b | input | 8 | Port B input pins (asynchronous) |
| pin_f | input | 8 | Port F input pins (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 8 | Write byte address |
| bus_wdata | input | 32 | Write data, bits [7:0] used |
| bus_raddr | input | 8 | Read byte address |
| bus_rdata | output | 32 | Combinational read data |
| irq_ab | output | 1 | Combined interrupt of ports A and B |
| irq_f | output | 8 | Per-line interrupts of port F |

## Verification
The bench targets the points where a sticky flag and a live level are easily confused. It checks that an acknowledge write leaves a level line asserted, and that a level line drops without any acknowledge. A design that latched levels, or let an acknowledge touch them, would fail one of these checks. The bench times a new edge to land in the same cycle as its acknowledge write; a design in which the clear wins would lose that event. It also raises an edge while the line is disabled, and separately disables a line that holds a flag, then enables it again. A design that only masked the output would let a stale interrupt fire in either case. Further checks cover the opposite-polarity edge, partial acknowledge masks, port F not driving the shared line, and upper data bits being dropped.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    localparam int NUM_PORTS = 3;
    localparam int LINES     = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int REG_KINDS = 5;
    localparam int PORT_IW   = $clog2(NUM_PORTS);

    typedef enum logic [2:0] {
        RK_NONE   = 3'd0,
        RK_SENSE  = 3'd1,
        RK_POL    = 3'd2,
        RK_ACK    = 3'd3,
        RK_ENABLE = 3'd4,
        RK_STATUS = 3'd5
    } reg_kind_e;

    typedef struct packed {
        logic               hit;
        logic [PORT_IW-1:0] port;
        reg_kind_e          kind;
    } reg_sel_t;

    // First register of each port; the others follow at 4-byte steps
    // in the order sense, polarity, acknowledge, enable, status.
    function automatic logic [ADDR_W-1:0] port_base(input int p);
        case (p)
            0:       return 8'h90;
            1:       return 8'hAC;
            default: return 8'h4C;
        endcase
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t sel;
        sel = '{hit: 1'b0, port: '0, kind: RK_NONE};
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int k = 0; k < REG_KINDS; k++) begin
                if (a == port_base(p) + ADDR_W'(4 * k)) begin
                    sel.hit  = 1'b1;
                    sel.port = PORT_IW'(p);
                    sel.kind = reg_kind_e'(k + 1);
                end
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_now,
    output logic [WIDTH-1:0] pin_prev
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            pin_now  <= '0;
            pin_prev <= '0;
        end else begin
            meta_q   <= pin_async;
            pin_now  <= meta_q;
            pin_prev <= pin_now;
        end
    end
endmodule

// File: rtl/gpio_port_sense.sv
module gpio_port_sense #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pin_now,
    input  logic [LINES-1:0] pin_prev,
    input  logic             wr_sense,
    input  logic             wr_pol,
    input  logic             wr_enable,
    input  logic             wr_ack,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] sense_q,
    output logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] enable_q,
    output logic [LINES-1:0] status
);
    logic [LINES-1:0] flag_q;
    logic [LINES-1:0] flag_d;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] fall;
    logic [LINES-1:0] event_hit;
    logic [LINES-1:0] level_hit;
    logic [LINES-1:0] ack_mask;

    always_comb begin
        rise      = pin_now & ~pin_prev;
        fall      = ~pin_now & pin_prev;
        event_hit = (pol_q & rise) | (~pol_q & fall);
        level_hit = ~(pin_now ^ pol_q);
        ack_mask  = wr_ack ? wdata : '0;
        // R5: a fresh event overrides the acknowledge of the same cycle
        // R3: a disabled line holds no flag
        flag_d    = enable_q & sense_q & (event_hit | (flag_q & ~ack_mask));
        status    = enable_q & ((sense_q & flag_q) | (~sense_q & level_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q  <= '0;
            pol_q    <= '0;
            enable_q <= '0;
            flag_q   <= '0;
        end else begin
            if (wr_sense)  sense_q  <= wdata;
            if (wr_pol)    pol_q    <= wdata;
            if (wr_enable) enable_q <= wdata;
            flag_q <= flag_d;
        end
    end
endmodule

// File: rtl/gpio_sense_ctrl.sv
module gpio_sense_ctrl
    import gpio_sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  pin_a,
    input  logic [LINES-1:0]  pin_b,
    input  logic [LINES-1:0]  pin_f,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_ab,
    output logic [LINES-1:0]  irq_f
);
    localparam int PORT_A = 0;
    localparam int PORT_B = 1;
    localparam int PORT_F = 2;

    logic [LINES-1:0] pins_in  [NUM_PORTS];
    logic [LINES-1:0] pin_now  [NUM_PORTS];
    logic [LINES-1:0] pin_prev [NUM_PORTS];
    logic [LINES-1:0] sense_v  [NUM_PORTS];
    logic [LINES-1:0] pol_v    [NUM_PORTS];
    logic [LINES-1:0] enable_v [NUM_PORTS];
    logic [LINES-1:0] status_v [NUM_PORTS];

    reg_sel_t wsel;
    reg_sel_t rsel;
    logic     unused_wdata_hi;

    assign pins_in[PORT_A] = pin_a;
    assign pins_in[PORT_B] = pin_b;
    assign pins_in[PORT_F] = pin_f;
    assign wsel            = decode_addr(bus_waddr);
    assign rsel            = decode_addr(bus_raddr);
    // R8: upper write data bits carry nothing
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LINES];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_hit;
        assign port_hit = bus_wr && wsel.hit && (wsel.port == PORT_IW'(p));

        gpio_pin_sync #(.WIDTH(LINES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .pin_async(pins_in[p]),
            .pin_now  (pin_now[p]),
            .pin_prev (pin_prev[p])
        );

        gpio_port_sense #(.LINES(LINES)) u_sense (
            .clk      (clk),
            .rst      (rst),
            .pin_now  (pin_now[p]),
            .pin_prev (pin_prev[p]),
            .wr_sense (port_hit && wsel.kind == RK_SENSE),
            .wr_pol   (port_hit && wsel.kind == RK_POL),
            .wr_enable(port_hit && wsel.kind == RK_ENABLE),
            .wr_ack   (port_hit && wsel.kind == RK_ACK),
            .wdata    (bus_wdata[LINES-1:0]),
            .sense_q  (sense_v[p]),
            .pol_q    (pol_v[p]),
            .enable_q (enable_v[p]),
            .status   (status_v[p])
        );
    end

    // R8: read mux; acknowledge and unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (rsel.hit && (int'(rsel.port) < NUM_PORTS)) begin
            case (rsel.kind)
                RK_SENSE:  bus_rdata[LINES-1:0] = sense_v[rsel.port];
                RK_POL:    bus_rdata[LINES-1:0] = pol_v[rsel.port];
                RK_ENABLE: bus_rdata[LINES-1:0] = enable_v[rsel.port];
                RK_STATUS: bus_rdata[LINES-1:0] = status_v[rsel.port];
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R6 and R7: interrupt routing
    assign irq_ab = (|status_v[PORT_A]) | (|status_v[PORT_B]);
    assign irq_f  = status_v[PORT_F];
endmodule

// File: rtl/gpio_sense_checks.sv
module gpio_sense_checks
    import gpio_sense_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_ab,
    input logic [LINES-1:0]  irq_f,
    input logic [LINES-1:0]  sense_v  [NUM_PORTS],
    input logic [LINES-1:0]  enable_v [NUM_PORTS],
    input logic [LINES-1:0]  status_v [NUM_PORTS]
);
    a_r6_shared_line: assert property (@(posedge clk) disable iff (rst)
        irq_ab == ((|status_v[0]) || (|status_v[1])));

    a_r7_per_line: assert property (@(posedge clk) disable iff (rst)
        irq_f == status_v[2]);

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:LINES] == '0);

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq_ab && irq_f == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        a_r3_enable_gates: assert property (@(posedge clk) disable iff (rst)
            (status_v[p] & ~enable_v[p]) == '0);

        // R2: with no register write, a set edge flag cannot drop
        a_r2_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (!bus_wr && ((status_v[p] & sense_v[p]) != '0))
            |=> ((status_v[p] & $past(status_v[p] & sense_v[p]))
                 == $past(status_v[p] & sense_v[p])));
    end
endmodule

bind gpio_sense_ctrl gpio_sense_checks i_checks (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .irq_ab   (irq_ab),
    .irq_f    (irq_f),
    .sense_v  (sense_v),
    .enable_v (enable_v),
    .status_v (status_v)
);

// File: tb/test_gpio_sense_ctrl.sv
`timescale 1ns/1ps
module test_gpio_sense_ctrl;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_PIN = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;
    localparam int NVEC = 64;

    // {op, addr, value, requirement number}; OP_PIN addr selects port 0=A 1=B 2=F,
    // OP_IRQ addr 0 compares irq_ab, addr 2 compares irq_f
    localparam logic [21:0] VECS [NVEC] = '{
        {OP_RD,  8'h90, 8'h00, 4'd9},   // R9 reset config
        {OP_RD,  8'hA0, 8'h00, 4'd9},   // R9 reset status
        {OP_IRQ, 8'h00, 8'h00, 4'd9},   // R9
        {OP_IRQ, 8'h02, 8'h00, 4'd9},   // R9
        {OP_WR,  8'h94, 8'h01, 4'd1},
        {OP_WR,  8'h9C, 8'h01, 4'd1},
        {OP_PIN, 8'h00, 8'h01, 4'd1},
        {OP_RD,  8'hA0, 8'h01, 4'd1},   // R1 high level
        {OP_IRQ, 8'h00, 8'h01, 4'd6},   // R6
        {OP_PIN, 8'h00, 8'h00, 4'd10},
        {OP_RD,  8'hA0, 8'h00, 4'd10},  // R10 level drops
        {OP_WR,  8'h9C, 8'h03, 4'd1},
        {OP_RD,  8'hA0, 8'h02, 4'd1},   // R1 low level
        {OP_PIN, 8'h00, 8'h02, 4'd1},
        {OP_RD,  8'hA0, 8'h00, 4'd1},   // R1
        {OP_PIN, 8'h00, 8'h00, 4'd1},
        {OP_WR,  8'h98, 8'h02, 4'd10},
        {OP_RD,  8'hA0, 8'h02, 4'd10},  // R10 ack ignored on level
        {OP_WR,  8'h9C, 8'h00, 4'd3},
        {OP_RD,  8'hA0, 8'h00, 4'd3},   // R3
        {OP_WR,  8'hAC, 8'h08, 4'd2},
        {OP_WR,  8'hB0, 8'h08, 4'd2},
        {OP_WR,  8'hB8, 8'h08, 4'd2},
        {OP_PIN, 8'h01, 8'h08, 4'd2},
        {OP_RD,  8'hBC, 8'h08, 4'd2},   // R2 rising
        {OP_IRQ, 8'h00, 8'h01, 4'd6},   // R6 via port B
        {OP_PIN, 8'h01, 8'h00, 4'd2},
        {OP_RD,  8'hBC, 8'h08, 4'd2},   // R2 sticky
        {OP_WR,  8'hB4, 8'h00, 4'd4},
        {OP_RD,  8'hBC, 8'h08, 4'd4},   // R4 zero bits keep flag
        {OP_WR,  8'hB4, 8'h08, 4'd4},
        {OP_RD,  8'hBC, 8'h00, 4'd4},   // R4 cleared
        {OP_IRQ, 8'h00, 8'h00, 4'd6},   // R6
        {OP_WR,  8'hAC, 8'h0C, 4'd2},
        {OP_WR,  8'hB8, 8'h0C, 4'd2},
        {OP_PIN, 8'h01, 8'h04, 4'd2},
        {OP_RD,  8'hBC, 8'h00, 4'd2},   // R2 opposite edge
        {OP_PIN, 8'h01, 8'h00, 4'd2},
        {OP_RD,  8'hBC, 8'h04, 4'd2},   // R2 falling
        {OP_WR,  8'hB4, 8'h04, 4'd4},
        {OP_RD,  8'hBC, 8'h00, 4'd4},   // R4
        {OP_WR,  8'hB8, 8'h00, 4'd3},
        {OP_PIN, 8'h01, 8'h08, 4'd3},
        {OP_WR,  8'hB8, 8'h0C, 4'd3},
        {OP_RD,  8'hBC, 8'h00, 4'd3},   // R3 edge while disabled
        {OP_PIN, 8'h01, 8'h00, 4'd3},
        {OP_PIN, 8'h01, 8'h08, 4'd3},
        {OP_RD,  8'hBC, 8'h08, 4'd2},   // R2
        {OP_WR,  8'hB8, 8'h04, 4'd3},
        {OP_WR,  8'hB8, 8'h0C, 4'd3},
        {OP_RD,  8'hBC, 8'h00, 4'd3},   // R3 held flag dropped
        {OP_PIN, 8'h01, 8'h00, 4'd3},
        {OP_WR,  8'h4C, 8'hFF, 4'd7},
        {OP_WR,  8'h50, 8'hFF, 4'd7},
        {OP_WR,  8'h58, 8'hF0, 4'd7},
        {OP_PIN, 8'h02, 8'hFF, 4'd7},
        {OP_RD,  8'h5C, 8'hF0, 4'd7},   // R7
        {OP_IRQ, 8'h02, 8'hF0, 4'd7},   // R7
        {OP_WR,  8'h54, 8'h30, 4'd4},
        {OP_IRQ, 8'h02, 8'hC0, 4'd4},   // R4 partial mask
        {OP_PIN, 8'h02, 8'h00, 4'd4},
        {OP_WR,  8'h54, 8'hFF, 4'd4},
        {OP_IRQ, 8'h02, 8'h00, 4'd4},   // R4
        {OP_RD,  8'h58, 8'hF0, 4'd8}    // R8 readback
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_a = '0;
    logic [7:0]  pin_b = '0;
    logic [7:0]  pin_f = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        irq_ab;
    logic [7:0]  irq_f;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_sense_ctrl i_gpio_sense_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pin_a    (pin_a),
        .pin_b    (pin_b),
        .pin_f    (pin_f),
        .bus_wr   (bus_wr),
        .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr),
        .bus_rdata(bus_rdata),
        .irq_ab   (irq_ab),
        .irq_f    (irq_f)
    );

    task automatic compare(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_waddr = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] port, input logic [7:0] val);
        @(negedge clk);
        case (port)
            8'd0:    pin_a = val;
            8'd1:    pin_b = val;
            default: pin_f = val;
        endcase
        repeat (4) @(negedge clk);
    endtask

    task automatic reg_read(input int req, input logic [7:0] addr, input logic [31:0] exp);
        bus_raddr = addr;
        #1;
        compare(req, bus_rdata, exp);
    endtask

    initial begin
        logic [21:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            case (v[21:20])
                OP_WR:  reg_write(v[19:12], {24'h0, v[11:4]});
                OP_PIN: set_pins(v[19:12], v[11:4]);
                OP_RD:  reg_read(int'(v[3:0]), v[19:12], {24'h0, v[11:4]});
                default: begin
                    #1;
                    if (v[19:12] == 8'd0) compare(int'(v[3:0]), {31'h0, irq_ab}, {31'h0, v[4]});
                    else                  compare(int'(v[3:0]), {24'h0, irq_f}, {24'h0, v[11:4]});
                end
            endcase
        end

        // R8: unmapped address and upper data bits
        reg_read(8, 8'h00, 32'h0);
        reg_read(8, 8'h54, 32'h0);
        reg_write(8'h58, 32'hABCD_0F0F);
        reg_read(8, 8'h58, 32'h0000_000F);

        // R5: edge coincident with an acknowledge write stays latched
        reg_write(8'h58, 32'h01);
        set_pins(8'd2, 8'h01);
        reg_read(5, 8'h5C, 32'h01);
        set_pins(8'd2, 8'h00);
        @(negedge clk);
        pin_f = 8'h01;
        @(negedge clk);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_waddr = 8'h54;
        bus_wdata = 32'h01;
        @(negedge clk);
        bus_wr    = 1'b0;
        reg_read(5, 8'h5C, 32'h01);
        reg_write(8'h54, 32'h01);
        reg_read(4, 8'h5C, 32'h00);

        // R9: reset clears everything again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        reg_read(9, 8'h58, 32'h0);
        #1;
        compare(9, {24'h0, irq_f}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule